// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Burst Address Counters

This block is a memory that two independent agents can use at once. Each side has its own clock and its own reset, and either side may read or write any word at any time. There is no arbitration and no busy signal. Every control, address and data input of a side is captured at the rising edge of that side's clock. The word address an access uses is always the value held in that side's burst counter. The counter can be cleared, loaded from the address pins, stepped by one, or left as it is. A burst is therefore one load beat followed by step beats.

Each side selects its read latency with a static mode pin. In flow-through mode, read data follows the capturing edge directly. In pipelined mode, it passes through one more output register. Each side has an active-low select and an active-high select, a write strobe, an output enable and one enable per byte lane. A word counts as selected only when both selects are asserted, so larger memories can be decoded from address bits with no glue logic. The output is data plus a valid flag. The default build is 1024 words of 16 bits; setting `ADDR_W` to 14 gives 16384 words.

Top module: `dpram_burst_top`

## Requirements
- R1: While reset is asserted, and after its release until the first read, `rd_valid_*` is 0 and `rd_data_*` is 0. The burst counter starts at word 0, so an access with no counter command after reset uses word 0.
- R2: An edge at which the side is selected with `wr_*`=1 writes the captured data into the word the counter holds after that edge. It writes only the lanes whose `be_*` bit is 1 (bit 1 = bits 15:8, bit 0 = bits 7:0), and the other lanes keep their contents.
- R3: With `pipe_*`=0, the read result for inputs captured at an edge appears on `rd_data_*`/`rd_valid_*` right after that same edge.
- R4: With `pipe_*`=1, the same result appears one clock edge later than in R3.
- R5: `rd_valid_*` is 1 only for a selected read with `oe_*`=1 and at least one byte enable set. Whenever `rd_valid_*` is 0, `rd_data_*` is 0.
- R6: In a valid read, any lane whose `be_*` bit is 0 reads as zero, using the lane mapping of R2.
- R7: The counter obeys, in falling priority, `clr_*` (to 0), `ld_*` (to `addr_*`), `inc_*` (plus one), and otherwise holds its value.
- R8: A step from the highest word wraps to word 0, and successive step beats reach successive words.
- R9: A word written on one side can be read on the other side, and both sides can read different words on the same edge.
- R10: A write strobe while either select is inactive leaves the memory unchanged.
- R11: Each byte lane returns the value of the most recent write to it from either side, so one word may hold lanes written by different sides. When both sides write the same lane at the same edge, the lane ends up holding one of the two values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous active-low reset |
| sel_n_a | input | 1 | Side A active-low select |
| sel_a | input | 1 | Side A active-high select |
| wr_a | input | 1 | Side A write (1) or read (0) |
| be_a | input | 2 | Side A byte-lane enables |
| oe_a | input | 1 | Side A read output enable |
| clr_a | input | 1 | Side A counter clear |
| ld_a | input | 1 | Side A counter load from addr_a |
| inc_a | input | 1 | Side A counter step |
| pipe_a | input | 1 | Side A latency mode, 1 = pipelined |
| addr_a | input | ADDR_W | Side A load address |
| wr_data_a | input | DATA_W | Side A write data |
| rd_data_a | output | DATA_W | Side A read data |
| rd_valid_a | output | 1 | Side A read data valid |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous active-low reset |
| sel_n_b | input | 1 | Side B active-low select |
| sel_b | input | 1 | Side B active-high select |
| wr_b | input | 1 | Side B write (1) or read (0) |
| be_b | input | 2 | Side B byte-lane enables |
| oe_b | input | 1 | Side B read output enable |
| clr_b | input | 1 | Side B counter clear |
| ld_b | input | 1 | Side B counter load from addr_b |
| inc_b | input | 1 | Side B counter step |
| pipe_b | input | 1 | Side B latency mode, 1 = pipelined |
| addr_b | input | ADDR_W | Side B load address |
| wr_data_b | input | DATA_W | Side B write data |
| rd_data_b | output | DATA_W | Side B read data |
| rd_valid_b | output | 1 | Side B read data valid |

## Verification
The latency properties assume that each side's mode pin changes only while that side is held in reset. The bench changes `pipe_*` only inside its reset routine. The properties also measure time from the release of the internally synchronised reset, so the bench waits several idle cycles after each release before it starts. No property predicts data for a lane that both sides write at the same edge, and the bench never makes the two sides write the same word on one edge.

// File: rtl/dpram_burst_pkg.sv
package dpram_burst_pkg;

  localparam int LANE_W = 8;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic oe;
  } port_ctl_t;

endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);

  localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | ld | inc;
    if (clr) begin
      cnt_d = '0;
    end else if (ld) begin
      cnt_d = din;
    end else if (inc) begin
      cnt_d = cnt_q + STEP;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign q = cnt_q;

endmodule

// File: rtl/dpram_bank.sv
module dpram_bank
  import dpram_burst_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter bit FLIP = 1'b0
) (
  input  logic                   clk,
  input  logic [DW/LANE_W-1:0]   wr_lane,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [DW/LANE_W-1:0]   peer_tag,
  input  logic [AW-1:0]          rd_addr_x,
  input  logic [AW-1:0]          rd_addr_y,
  output logic [DW-1:0]          rd_data_x,
  output logic [DW-1:0]          rd_data_y,
  output logic [DW/LANE_W-1:0]   tag_x,
  output logic [DW/LANE_W-1:0]   tag_y
);

  localparam int LANES = DW / LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem   [DEPTH];
  logic [LANES-1:0] tag_m [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_lane[l]) begin
        mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        tag_m[wr_addr][l]                <= peer_tag[l] ^ FLIP;
      end
    end
  end

  assign rd_data_x = mem[rd_addr_x];
  assign rd_data_y = mem[rd_addr_y];
  assign tag_x     = tag_m[rd_addr_x];
  assign tag_y     = tag_m[rd_addr_y];

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_burst_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [DW/LANE_W-1:0] be,
  input  logic                 oe,
  input  logic                 clr,
  input  logic                 ld,
  input  logic                 inc,
  input  logic                 pipe,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [DW-1:0]        a_data,
  input  logic [DW-1:0]        b_data,
  input  logic [DW/LANE_W-1:0] a_tag,
  input  logic [DW/LANE_W-1:0] b_tag,
  output logic [AW-1:0]        acc_addr,
  output logic [DW/LANE_W-1:0] wr_lane,
  output logic [DW-1:0]        wr_word,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid
);

  localparam int LANES = DW / LANE_W;

  port_ctl_t        ctl_q, ctl_d;
  logic [LANES-1:0] be_q, be_d;
  logic [DW-1:0]    wdata_q;
  logic             wdata_en;
  logic             pstage_en;
  logic [DW-1:0]    p_data_q;
  logic             p_valid_q;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    s1_data;
  logic             s1_valid;
  lat_mode_e        mode;

  dpram_addr_ctr #(.AW(AW)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .ld    (ld),
    .inc   (inc),
    .din   (addr),
    .q     (acc_addr)
  );

  always_comb begin
    mode      = lat_mode_e'(pipe);
    ctl_d.sel = ~sel_n & sel;
    ctl_d.wr  = wr;
    ctl_d.oe  = oe;
    be_d      = be;
    wdata_en  = ~sel_n & sel & wr;
    pstage_en = (mode == LAT_PIPE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      p_data_q  <= '0;
      p_valid_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      be_q  <= be_d;
      if (wdata_en) begin
        wdata_q <= wr_data;
      end
      if (pstage_en) begin
        p_data_q  <= s1_data;
        p_valid_q <= s1_valid;
      end
    end
  end

  assign s1_valid = ctl_q.sel & ~ctl_q.wr & ctl_q.oe & (|be_q);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (a_tag[l] == b_tag[l])
                                        ? a_data[l*LANE_W +: LANE_W]
                                        : b_data[l*LANE_W +: LANE_W];
    assign s1_data[l*LANE_W +: LANE_W] = (s1_valid & be_q[l])
                                         ? merged[l*LANE_W +: LANE_W]
                                         : '0;
    assign wr_lane[l] = ctl_q.sel & ctl_q.wr & be_q[l];
  end

  assign wr_word  = wdata_q;
  assign rd_data  = (mode == LAT_PIPE) ? p_data_q  : s1_data;
  assign rd_valid = (mode == LAT_PIPE) ? p_valid_q : s1_valid;

endmodule

// File: rtl/dpram_burst_top.sv
module dpram_burst_top
  import dpram_burst_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk_a,
  input  logic                     rst_a_n,
  input  logic                     sel_n_a,
  input  logic                     sel_a,
  input  logic                     wr_a,
  input  logic [DATA_W/LANE_W-1:0] be_a,
  input  logic                     oe_a,
  input  logic                     clr_a,
  input  logic                     ld_a,
  input  logic                     inc_a,
  input  logic                     pipe_a,
  input  logic [ADDR_W-1:0]        addr_a,
  input  logic [DATA_W-1:0]        wr_data_a,
  output logic [DATA_W-1:0]        rd_data_a,
  output logic                     rd_valid_a,
  input  logic                     clk_b,
  input  logic                     rst_b_n,
  input  logic                     sel_n_b,
  input  logic                     sel_b,
  input  logic                     wr_b,
  input  logic [DATA_W/LANE_W-1:0] be_b,
  input  logic                     oe_b,
  input  logic                     clr_b,
  input  logic                     ld_b,
  input  logic                     inc_b,
  input  logic                     pipe_b,
  input  logic [ADDR_W-1:0]        addr_b,
  input  logic [DATA_W-1:0]        wr_data_b,
  output logic [DATA_W-1:0]        rd_data_b,
  output logic                     rd_valid_b
);

  localparam int LANES = DATA_W / LANE_W;

  logic              rst_a_sync_n, rst_b_sync_n;
  logic [ADDR_W-1:0] acc_a, acc_b;
  logic [LANES-1:0]  lane_we_a, lane_we_b;
  logic [DATA_W-1:0] word_a, word_b;
  logic [DATA_W-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
  logic [LANES-1:0]  tag_a_at_a, tag_a_at_b, tag_b_at_a, tag_b_at_b;

  dpram_rst_sync #(.STAGES(2)) rs_a_i (
    .clk(clk_a), .rst_n(rst_a_n), .rst_sync_n(rst_a_sync_n)
  );

  dpram_rst_sync #(.STAGES(2)) rs_b_i (
    .clk(clk_b), .rst_n(rst_b_n), .rst_sync_n(rst_b_sync_n)
  );

  dpram_port #(.AW(ADDR_W), .DW(DATA_W)) port_a_i (
    .clk(clk_a), .rst_n(rst_a_sync_n),
    .sel_n(sel_n_a), .sel(sel_a), .wr(wr_a), .be(be_a), .oe(oe_a),
    .clr(clr_a), .ld(ld_a), .inc(inc_a), .pipe(pipe_a),
    .addr(addr_a), .wr_data(wr_data_a),
    .a_data(bank_a_at_a), .b_data(bank_b_at_a),
    .a_tag(tag_a_at_a), .b_tag(tag_b_at_a),
    .acc_addr(acc_a), .wr_lane(lane_we_a), .wr_word(word_a),
    .rd_data(rd_data_a), .rd_valid(rd_valid_a)
  );

  dpram_port #(.AW(ADDR_W), .DW(DATA_W)) port_b_i (
    .clk(clk_b), .rst_n(rst_b_sync_n),
    .sel_n(sel_n_b), .sel(sel_b), .wr(wr_b), .be(be_b), .oe(oe_b),
    .clr(clr_b), .ld(ld_b), .inc(inc_b), .pipe(pipe_b),
    .addr(addr_b), .wr_data(wr_data_b),
    .a_data(bank_a_at_b), .b_data(bank_b_at_b),
    .a_tag(tag_a_at_b), .b_tag(tag_b_at_b),
    .acc_addr(acc_b), .wr_lane(lane_we_b), .wr_word(word_b),
    .rd_data(rd_data_b), .rd_valid(rd_valid_b)
  );

  // Side A's bank makes its tag equal to B's; side B's bank makes it differ.
  dpram_bank #(.AW(ADDR_W), .DW(DATA_W), .FLIP(1'b0)) bank_a_i (
    .clk(clk_a), .wr_lane(lane_we_a), .wr_addr(acc_a), .wr_data(word_a),
    .peer_tag(tag_b_at_a),
    .rd_addr_x(acc_a), .rd_addr_y(acc_b),
    .rd_data_x(bank_a_at_a), .rd_data_y(bank_a_at_b),
    .tag_x(tag_a_at_a), .tag_y(tag_a_at_b)
  );

  dpram_bank #(.AW(ADDR_W), .DW(DATA_W), .FLIP(1'b1)) bank_b_i (
    .clk(clk_b), .wr_lane(lane_we_b), .wr_addr(acc_b), .wr_data(word_b),
    .peer_tag(tag_a_at_b),
    .rd_addr_x(acc_a), .rd_addr_y(acc_b),
    .rd_data_x(bank_b_at_a), .rd_data_y(bank_b_at_b),
    .tag_x(tag_b_at_a), .tag_y(tag_b_at_b)
  );

endmodule

// File: rtl/dpram_port_chk.sv
module dpram_port_chk
  import dpram_burst_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_n,
  input logic                 sel,
  input logic                 wr,
  input logic [DW/LANE_W-1:0] be,
  input logic                 oe,
  input logic                 clr,
  input logic                 ld,
  input logic                 inc,
  input logic                 pipe,
  input logic [AW-1:0]        addr,
  input logic [AW-1:0]        acc_addr,
  input logic [DW-1:0]        rd_data,
  input logic                 rd_valid
);

  localparam int LANES = DW / LANE_W;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic          rd_req;
  logic [DW-1:0] lane_mask;

  assign rd_req = ~sel_n & sel & ~wr & oe & (|be);

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
  end

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  assert_flow_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(rst_n)) |-> (rd_valid == $past(rd_req)));

  assert_pipe_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && $past(rst_n) && $past(rst_n, 2)) |-> (rd_valid == $past(rd_req, 2)));

  assert_lane_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && $past(rst_n)) |-> ((rd_data & ~$past(lane_mask)) == '0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr)) |-> (acc_addr == '0));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld && !clr)) |-> (acc_addr == $past(addr)));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(inc && !ld && !clr)) |-> (acc_addr == $past(acc_addr) + ONE));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!inc && !ld && !clr)) |-> $stable(acc_addr));

endmodule

bind dpram_burst_top dpram_port_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_a_i (
  .clk(clk_a), .rst_n(rst_a_sync_n), .sel_n(sel_n_a), .sel(sel_a), .wr(wr_a),
  .be(be_a), .oe(oe_a), .clr(clr_a), .ld(ld_a), .inc(inc_a), .pipe(pipe_a),
  .addr(addr_a), .acc_addr(acc_a), .rd_data(rd_data_a), .rd_valid(rd_valid_a)
);

bind dpram_burst_top dpram_port_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_b_i (
  .clk(clk_b), .rst_n(rst_b_sync_n), .sel_n(sel_n_b), .sel(sel_b), .wr(wr_b),
  .be(be_b), .oe(oe_b), .clr(clr_b), .ld(ld_b), .inc(inc_b), .pipe(pipe_b),
  .addr(addr_b), .acc_addr(acc_b), .rd_data(rd_data_b), .rd_valid(rd_valid_b)
);

// File: tb/dpram_burst_top_tb_top.sv
module dpram_burst_top_tb_top;

  typedef struct packed {
    logic        cs_n;
    logic        cs;
    logic        clr;
    logic        ld;
    logic        inc;
    logic        wr;
    logic [1:0]  be;
    logic        oe;
    logic [9:0]  addr;
    logic [15:0] wdata;
  } op_t;

  typedef struct packed {
    op_t         op;
    logic        ev;
    logic [15:0] ed;
    logic [23:0] tag;
  } vec_t;

  localparam op_t IDLE = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 10'h000, 16'h0000};

  // Side A, flow-through; expected outputs right after the capturing edge.
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h010,16'h1234}, 1'b0, 16'h0000, "R2 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,10'h000,16'hABCD}, 1'b0, 16'h0000, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,10'h000,16'h5A5A}, 1'b0, 16'h0000, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b1,10'h010,16'h0000}, 1'b1, 16'h1234, "R3 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,1'b1,10'h000,16'h0000}, 1'b1, 16'hABCD, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,1'b1,10'h000,16'h0000}, 1'b1, 16'h5A5A, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b01,1'b0,10'h011,16'hFF77}, 1'b0, 16'h0000, "R2 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b11,1'b1,10'h000,16'h0000}, 1'b1, 16'hAB77, "R2 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10,1'b1,10'h000,16'h0000}, 1'b1, 16'hAB00, "R6 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,1'b0,10'h000,16'h0000}, 1'b0, 16'h0000, "R5 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,10'h000,16'h0000}, 1'b0, 16'h0000, "R5 "},
    '{'{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,10'h155,16'h0F0F}, 1'b0, 16'h0000, "R7 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b11,1'b1,10'h000,16'h0000}, 1'b1, 16'h0F0F, "R7 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h3FF,16'hC3C3}, 1'b0, 16'h0000, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,1'b1,10'h000,16'h0000}, 1'b1, 16'h0F0F, "R8 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b1,10'h3FF,16'h0000}, 1'b1, 16'hC3C3, "R7 "},
    '{'{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,2'b11,1'b1,10'h010,16'h0000}, 1'b1, 16'h0F0F, "R7 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,1'b1,10'h012,16'h0000}, 1'b1, 16'h5A5A, "R7 "},
    '{'{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h010,16'hDEAD}, 1'b0, 16'h0000, "R10"},
    '{'{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,10'h011,16'hBEEF}, 1'b0, 16'h0000, "R10"},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b1,10'h010,16'h0000}, 1'b1, 16'h1234, "R10"},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b1,10'h011,16'h0000}, 1'b1, 16'hAB77, "R10"},
    '{'{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,1'b1,10'h010,16'h0000}, 1'b0, 16'h0000, "R5 "},
    '{'{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b01,1'b1,10'h012,16'h0000}, 1'b1, 16'h005A, "R6 "}
  };

  logic        clk;
  logic        rst_n;
  logic        pipe_a, pipe_b;
  op_t         op_a, op_b;
  logic [15:0] rd_data_a, rd_data_b;
  logic        rd_valid_a, rd_valid_b;
  int          n_checks;
  int          n_fail;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dpram_burst_top #(.ADDR_W(10), .DATA_W(16)) dut_i (
    .clk_a(clk), .rst_a_n(rst_n), .sel_n_a(op_a.cs_n), .sel_a(op_a.cs),
    .wr_a(op_a.wr), .be_a(op_a.be), .oe_a(op_a.oe), .clr_a(op_a.clr),
    .ld_a(op_a.ld), .inc_a(op_a.inc), .pipe_a(pipe_a), .addr_a(op_a.addr),
    .wr_data_a(op_a.wdata), .rd_data_a(rd_data_a), .rd_valid_a(rd_valid_a),
    .clk_b(clk), .rst_b_n(rst_n), .sel_n_b(op_b.cs_n), .sel_b(op_b.cs),
    .wr_b(op_b.wr), .be_b(op_b.be), .oe_b(op_b.oe), .clr_b(op_b.clr),
    .ld_b(op_b.ld), .inc_b(op_b.inc), .pipe_b(pipe_b), .addr_b(op_b.addr),
    .wr_data_b(op_b.wdata), .rd_data_b(rd_data_b), .rd_valid_b(rd_valid_b)
  );

  task automatic check(input string req, input logic gv, input logic [15:0] gd,
                       input logic ev, input logic [15:0] ed);
    n_checks++;
    if (gv !== ev || gd !== ed) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%h, expected valid=%0b data=%h", req, gv, gd, ev, ed);
    end
  endtask

  task automatic do_reset(input logic pa, input logic pb);
    @(negedge clk);
    rst_n  = 1'b0;
    pipe_a = pa;
    pipe_b = pb;
    op_a   = IDLE;
    op_b   = IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic op_t mk(input logic ld, input logic wr, input logic [1:0] be,
                             input logic [9:0] a, input logic [15:0] d);
    op_t o;
    o = '{1'b0, 1'b1, 1'b0, ld, 1'b0, wr, be, ~wr, a, d};
    return o;
  endfunction

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    pipe_a   = 1'b0;
    pipe_b   = 1'b0;
    op_a     = IDLE;
    op_b     = IDLE;

    // R1: outputs quiet and counter at word 0 after reset
    do_reset(1'b0, 1'b0);
    check("R1", rd_valid_a, rd_data_a, 1'b0, 16'h0000);
    check("R1", rd_valid_b, rd_data_b, 1'b0, 16'h0000);
    op_a = mk(1'b0, 1'b1, 2'b11, 10'h155, 16'h6006);
    @(negedge clk);
    check("R1", rd_valid_a, rd_data_a, 1'b0, 16'h0000);
    op_a = mk(1'b1, 1'b0, 2'b11, 10'h000, 16'h0000);
    @(negedge clk);
    check("R1", rd_valid_a, rd_data_a, 1'b1, 16'h6006);

    // table walk on side A
    for (int i = 0; i < NV; i++) begin
      op_a = TBL[i].op;
      @(negedge clk);
      check(string'(TBL[i].tag), rd_valid_a, rd_data_a, TBL[i].ev, TBL[i].ed);
    end
    op_a = IDLE;

    // R4: side A pipelined, one extra edge
    do_reset(1'b1, 1'b0);
    op_a = mk(1'b1, 1'b0, 2'b11, 10'h010, 16'h0000);
    @(negedge clk);
    check("R4", rd_valid_a, rd_data_a, 1'b0, 16'h0000);
    op_a = mk(1'b1, 1'b0, 2'b11, 10'h011, 16'h0000);
    @(negedge clk);
    check("R4", rd_valid_a, rd_data_a, 1'b1, 16'h1234);
    op_a = IDLE;
    @(negedge clk);
    check("R4", rd_valid_a, rd_data_a, 1'b1, 16'hAB77);
    @(negedge clk);
    check("R4", rd_valid_a, rd_data_a, 1'b0, 16'h0000);

    // R9 / R11: cross-side visibility and per-lane latest writer
    do_reset(1'b0, 1'b0);
    op_b = mk(1'b1, 1'b0, 2'b11, 10'h011, 16'h0000);
    @(negedge clk);
    check("R9", rd_valid_b, rd_data_b, 1'b1, 16'hAB77);
    op_b = mk(1'b1, 1'b1, 2'b10, 10'h011, 16'h9900);
    @(negedge clk);
    check("R2", rd_valid_b, rd_data_b, 1'b0, 16'h0000);
    op_b = IDLE;
    op_a = mk(1'b1, 1'b0, 2'b11, 10'h011, 16'h0000);
    @(negedge clk);
    check("R11", rd_valid_a, rd_data_a, 1'b1, 16'h9977);
    op_a = mk(1'b1, 1'b1, 2'b01, 10'h011, 16'h0055);
    @(negedge clk);
    op_a = IDLE;
    op_b = mk(1'b1, 1'b0, 2'b11, 10'h011, 16'h0000);
    @(negedge clk);
    check("R11", rd_valid_b, rd_data_b, 1'b1, 16'h9955);
    op_a = mk(1'b1, 1'b0, 2'b11, 10'h012, 16'h0000);
    op_b = mk(1'b1, 1'b0, 2'b11, 10'h3FF, 16'h0000);
    @(negedge clk);
    check("R9", rd_valid_a, rd_data_a, 1'b1, 16'h5A5A);
    check("R9", rd_valid_b, rd_data_b, 1'b1, 16'hC3C3);
    op_a = IDLE;
    op_b = IDLE;
    @(negedge clk);
    check("R5", rd_valid_b, rd_data_b, 1'b0, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule